// File: doc/BRIEF.md
# Watchdog Frequency Fallback Controller

This block supervises the frequency-select code that feeds a clock synthesizer. During reset it samples a 5-bit select code from strap pins and keeps it for the rest of the run. Software may program its own select code in a register and switch to it with a program-enable bit. The final choice is the active select output.

A watchdog counts ticks of a fixed-period timebase, for example a 290 ms interval. The tick arrives as a one-cycle pulse on `tick_i`, so a bench can use a short period. While the watchdog is enabled, software must pulse `service_i` before the programmed number of ticks has passed. If it does not, the alarm flag is set. The active select is then forced to a programmable safe code, which uses the same encoding as the normal select. It stays forced until software acknowledges the alarm.

All control and status pins are plain levels or one-cycle strobes. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `wdt_freq_guard`

## Requirements
- R1: The select code on `pin_sel_i` is captured at every clock edge while `rst_n` is low. After reset is released, changes on `pin_sel_i` have no effect on the captured code.
- R2: `prog_en` is set by `ctl_we_i` and resets to 0. When it is 0, `active_sel_o` shows the captured pin code. When it is 1, `active_sel_o` shows the programmed select register, which is loaded by `fsel_we_i`.
- R3: The timeout register resets to CNT_INIT, which is 16. With the watchdog enabled, `alarm_o` rises in the cycle after the N-th tick counted from the last reload, where N is the timeout value.
- R4: `wd_en` is set by `ctl_we_i` and resets to 0. While it is 0, ticks are not counted and no alarm can be raised. Enabling the watchdog again does not reload the counter, so counting resumes where it stopped.
- R5: A pulse on `service_i` reloads the counter with the timeout value. A full N ticks are then needed before an alarm.
- R6: A write on `tmo_we_i` stores the new timeout value and restarts the count from that value.
- R7: While `alarm_o` is 1, `active_sel_o` equals the safe code last written through `ctl_safe_sel_i`. This holds whatever the value of `prog_en`.
- R8: The alarm is sticky. A service pulse, further ticks, or a control write with `ctl_wd_en_i`=1 and `ctl_alarm_i`=1 leave it set. A control write with `ctl_wd_en_i`=0 or with `ctl_alarm_i`=0 clears it on the next edge.
- R9: Clearing a set alarm reloads the counter. A full N ticks are then needed before the next alarm.
- R10: If a service pulse and a tick arrive in the same cycle, the reload takes priority and that tick is not counted.
- R11: A timeout value of 0 or 1 raises the alarm on the first counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Pin select is sampled while it is low |
| tick_i | input | 1 | One-cycle timebase tick |
| pin_sel_i | input | SEL_W | Strap-pin select code |
| service_i | input | 1 | Watchdog service pulse |
| tmo_we_i | input | 1 | Timeout register write strobe |
| tmo_val_i | input | CNT_W | Timeout value, in ticks |
| fsel_we_i | input | 1 | Programmed select register write strobe |
| fsel_val_i | input | SEL_W | Programmed select value |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_prog_en_i | input | 1 | Program-enable value to write |
| ctl_wd_en_i | input | 1 | Watchdog enable value to write |
| ctl_alarm_i | input | 1 | Alarm value to write. 0 clears the alarm, 1 keeps it |
| ctl_safe_sel_i | input | SEL_W | Safe select code to write |
| active_sel_o | output | SEL_W | Active frequency-select code |
| alarm_o | output | 1 | Watchdog alarm status |

## Verification
The bench builds the block with CNT_W=5 and CNT_INIT=16. This makes the whole timeout range 0 to 31 small enough to sweep. For each timeout value, the alarm is checked after every single tick, and the fallback code is checked once the alarm is set. All 32 strap codes are also captured through separate resets, so the pin latch is covered across its full code space. At these sizes the rare cases can be reached directly: timeouts of 0 and 1, a service pulse and a tick in the same cycle, a pause while disabled, and both ways of clearing the alarm.

// File: rtl/wdg_guard_pkg.sv
package wdg_guard_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_REG  = 2'd1,
    SRC_SAFE = 2'd2
  } sel_src_e;
endpackage

// File: rtl/wdg_pin_latch.sv
module wdg_pin_latch #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] lat_o
);
  logic [W-1:0] lat_q;

  // sample the straps while reset is held, freeze afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= pins_i;
  end

  assign lat_o = lat_q;

  assert_pins_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(lat_q));
endmodule

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs #(
  parameter int unsigned SEL_W     = 5,
  parameter logic [SEL_W-1:0] SAFE_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsel_we_i,
  input  logic [SEL_W-1:0] fsel_val_i,
  input  logic             ctl_we_i,
  input  logic             ctl_prog_en_i,
  input  logic             ctl_wd_en_i,
  input  logic             ctl_alarm_i,
  input  logic [SEL_W-1:0] ctl_safe_sel_i,
  output logic             prog_en_o,
  output logic             wd_en_o,
  output logic [SEL_W-1:0] safe_sel_o,
  output logic [SEL_W-1:0] fsel_o,
  output logic             alarm_clr_o
);
  logic             prog_en_q, wd_en_q;
  logic [SEL_W-1:0] safe_q, fsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_en_q <= 1'b0;
      wd_en_q   <= 1'b0;
      safe_q    <= SAFE_INIT;
      fsel_q    <= '0;
    end else begin
      if (ctl_we_i) begin
        prog_en_q <= ctl_prog_en_i;
        wd_en_q   <= ctl_wd_en_i;
        safe_q    <= ctl_safe_sel_i;
      end
      if (fsel_we_i) fsel_q <= fsel_val_i;
    end
  end

  // disabling or writing the alarm bit low acknowledges the alarm
  assign alarm_clr_o = ctl_we_i && (!ctl_wd_en_i || !ctl_alarm_i);
  assign prog_en_o   = prog_en_q;
  assign wd_en_o     = wd_en_q;
  assign safe_sel_o  = safe_q;
  assign fsel_o      = fsel_q;

  assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we_i |=> $stable(prog_en_q) && $stable(wd_en_q) && $stable(safe_q));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CNT_INIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             service_i,
  input  logic             tmo_we_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  input  logic             alarm_clr_i,
  output logic             alarm_o
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(CNT_INIT);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] tmo_q, cnt_q, reload_v;
  logic             alarm_q;

  assign reload_v = tmo_we_i ? tmo_val_i : tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo_q   <= INIT_V;
      cnt_q   <= INIT_V;
      alarm_q <= 1'b0;
    end else begin
      if (tmo_we_i) tmo_q <= tmo_val_i;
      if (alarm_clr_i && alarm_q) begin
        alarm_q <= 1'b0;
        cnt_q   <= reload_v;
      end else if (tmo_we_i || service_i) begin
        cnt_q <= reload_v;
      end else if (en_i && !alarm_q && tick_i) begin
        if (cnt_q <= ONE_V) alarm_q <= 1'b1;
        else                cnt_q   <= cnt_q - ONE_V;
      end
    end
  end

  assign alarm_o = alarm_q;

  assert_trip_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(tick_i && en_i));
  assert_frozen_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !tmo_we_i && !service_i && !alarm_clr_i) |=> $stable(cnt_q) && $stable(alarm_q));
  assert_service_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (service_i && !tmo_we_i && !alarm_clr_i) |=> cnt_q == $past(tmo_q));
  assert_alarm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !alarm_clr_i) |=> alarm_q);
  assert_alarm_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr_i |=> !alarm_q);
endmodule

// File: rtl/wdg_sel_mux.sv
module wdg_sel_mux
  import wdg_guard_pkg::*;
#(
  parameter int unsigned SEL_W = 5
) (
  input  logic             alarm_i,
  input  logic             prog_en_i,
  input  logic [SEL_W-1:0] pin_sel_i,
  input  logic [SEL_W-1:0] reg_sel_i,
  input  logic [SEL_W-1:0] safe_sel_i,
  output logic [SEL_W-1:0] sel_o
);
  sel_src_e src;

  // fallback outranks the program-enable choice
  always_comb begin
    if (alarm_i)        src = SRC_SAFE;
    else if (prog_en_i) src = SRC_REG;
    else                src = SRC_PIN;
  end

  for (genvar b = 0; b < SEL_W; b++) begin : g_bit
    always_comb begin
      unique case (src)
        SRC_SAFE: sel_o[b] = safe_sel_i[b];
        SRC_REG:  sel_o[b] = reg_sel_i[b];
        default:  sel_o[b] = pin_sel_i[b];
      endcase
    end
  end
endmodule

// File: rtl/wdt_freq_guard.sv
module wdt_freq_guard #(
  parameter int unsigned SEL_W    = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned CNT_INIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] pin_sel_i,
  input  logic             service_i,
  input  logic             tmo_we_i,
  input  logic [CNT_W-1:0] tmo_val_i,
  input  logic             fsel_we_i,
  input  logic [SEL_W-1:0] fsel_val_i,
  input  logic             ctl_we_i,
  input  logic             ctl_prog_en_i,
  input  logic             ctl_wd_en_i,
  input  logic             ctl_alarm_i,
  input  logic [SEL_W-1:0] ctl_safe_sel_i,
  output logic [SEL_W-1:0] active_sel_o,
  output logic             alarm_o
);
  logic [SEL_W-1:0] pin_lat, reg_sel, safe_sel;
  logic             prog_en, wd_en, alarm_clr, alarm;

  wdg_pin_latch #(.W(SEL_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .pins_i(pin_sel_i), .lat_o(pin_lat));

  wdg_cfg_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .fsel_we_i(fsel_we_i), .fsel_val_i(fsel_val_i),
    .ctl_we_i(ctl_we_i), .ctl_prog_en_i(ctl_prog_en_i),
    .ctl_wd_en_i(ctl_wd_en_i), .ctl_alarm_i(ctl_alarm_i),
    .ctl_safe_sel_i(ctl_safe_sel_i),
    .prog_en_o(prog_en), .wd_en_o(wd_en), .safe_sel_o(safe_sel),
    .fsel_o(reg_sel), .alarm_clr_o(alarm_clr));

  wdg_countdown #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .en_i(wd_en),
    .service_i(service_i), .tmo_we_i(tmo_we_i), .tmo_val_i(tmo_val_i),
    .alarm_clr_i(alarm_clr), .alarm_o(alarm));

  wdg_sel_mux #(.SEL_W(SEL_W)) u_mux (
    .alarm_i(alarm), .prog_en_i(prog_en), .pin_sel_i(pin_lat),
    .reg_sel_i(reg_sel), .safe_sel_i(safe_sel), .sel_o(active_sel_o));

  assign alarm_o = alarm;

  assert_alarm_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> wd_en);
  assert_safe_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_o |-> active_sel_o == safe_sel);
endmodule

// File: tb/wdt_freq_guard_bench.sv
module wdt_freq_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 5;
  localparam int CNT_W = 5;
  localparam int CNT_INIT = 16;
  localparam int MAX_CYC = 100000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, service = 1'b0;
  logic [SEL_W-1:0] pins = '0, fsel_val = '0, safe_val = '0, active;
  logic tmo_we = 1'b0, fsel_we = 1'b0, ctl_we = 1'b0;
  logic [CNT_W-1:0] tmo_val = '0;
  logic c_prog = 1'b0, c_en = 1'b0, c_alarm = 1'b1, alarm;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_freq_guard #(.SEL_W(SEL_W), .CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_wdt_freq_guard (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pin_sel_i(pins), .service_i(service),
    .tmo_we_i(tmo_we), .tmo_val_i(tmo_val), .fsel_we_i(fsel_we), .fsel_val_i(fsel_val),
    .ctl_we_i(ctl_we), .ctl_prog_en_i(c_prog), .ctl_wd_en_i(c_en), .ctl_alarm_i(c_alarm),
    .ctl_safe_sel_i(safe_val), .active_sel_o(active), .alarm_o(alarm));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > MAX_CYC) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected below %0d", cyc, MAX_CYC);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one-cycle strobe helper: inputs already set, pulse for one edge, sample after
  task automatic step();
    @(negedge clk);
    tick = 0; service = 0; tmo_we = 0; fsel_we = 0; ctl_we = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1; step();
  endtask

  task automatic wr_ctl(input logic p, input logic e, input logic a, input logic [SEL_W-1:0] s);
    @(negedge clk); c_prog = p; c_en = e; c_alarm = a; safe_val = s; ctl_we = 1; step();
  endtask

  task automatic wr_tmo(input int n);
    @(negedge clk); tmo_val = CNT_W'(n); tmo_we = 1; step();
  endtask

  task automatic do_reset(input logic [SEL_W-1:0] p);
    @(negedge clk); rst_n = 0; pins = p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    c_prog = 0; c_en = 0; c_alarm = 1; safe_val = '0;
  endtask

  initial begin
    // R1: all strap codes captured and held after reset
    for (int p = 0; p < 32; p++) begin
      do_reset(SEL_W'(p));
      chk("R1 captured strap", int'(active), p);
      chk("R2 reset alarm low", int'(alarm), 0);
      pins = SEL_W'(p) ^ 5'h1F;
      @(negedge clk);
      chk("R1 strap ignored after reset", int'(active), p);
    end

    // R2: source selection
    do_reset(5'h0A);
    @(negedge clk); fsel_val = 5'h13; fsel_we = 1; step();
    chk("R2 prog_en 0 keeps pins", int'(active), 'h0A);
    wr_ctl(1, 0, 1, 5'h07);
    chk("R2 prog_en 1 uses register", int'(active), 'h13);
    @(negedge clk); fsel_val = 5'h1C; fsel_we = 1; step();
    chk("R2 register follows write", int'(active), 'h1C);
    wr_ctl(0, 0, 1, 5'h07);
    chk("R2 back to pins", int'(active), 'h0A);

    // R3: default timeout 16, R7 fallback code
    do_reset(5'h03);
    wr_ctl(0, 1, 1, 5'h15);
    for (int k = 1; k <= 16; k++) begin
      do_tick();
      chk("R3 default timeout alarm", int'(alarm), (k >= 16) ? 1 : 0);
    end
    chk("R7 safe code forced", int'(active), 'h15);
    wr_ctl(0, 1, 0, 5'h15);
    chk("R8 clear by alarm bit", int'(alarm), 0);
    chk("R8 pins restored", int'(active), 'h03);

    // R3/R11/R7/R8: sweep every timeout value
    @(negedge clk); fsel_val = 5'h09; fsel_we = 1; step();
    for (int n = 0; n < 32; n++) begin
      int lim;
      logic [SEL_W-1:0] sf;
      lim = (n < 1) ? 1 : n;
      sf = SEL_W'(n) ^ 5'h15;
      wr_ctl(1, 1, 1, sf);
      wr_tmo(n);
      for (int k = 1; k <= lim; k++) begin
        do_tick();
        @(negedge clk); // idle cycle: no tick, must not count
        chk((n < 2) ? "R11 short timeout" : "R3 sweep timeout", int'(alarm), (k >= lim) ? 1 : 0);
      end
      chk("R7 sweep safe code", int'(active), int'(sf));
      @(negedge clk); service = 1; step();
      chk("R8 service keeps alarm", int'(alarm), 1);
      wr_ctl(1, 1, 1, sf);
      chk("R8 write 1 keeps alarm", int'(alarm), 1);
      if (n % 2 == 0) wr_ctl(1, 0, 1, sf);
      else            wr_ctl(1, 1, 0, sf);
      chk("R8 clear", int'(alarm), 0);
      chk("R2 register select after clear", int'(active), 'h09);
    end

    // R9: clear reloads the count
    wr_ctl(0, 1, 1, 5'h02);
    wr_tmo(3);
    repeat (3) do_tick();
    chk("R9 trip before clear", int'(alarm), 1);
    wr_ctl(0, 1, 0, 5'h02);
    do_tick(); do_tick();
    chk("R9 full count after clear", int'(alarm), 0);
    do_tick();
    chk("R9 trip after reload", int'(alarm), 1);
    wr_ctl(0, 0, 1, 5'h02);

    // R5: service reloads
    wr_ctl(0, 1, 1, 5'h02);
    wr_tmo(10);
    repeat (7) do_tick();
    @(negedge clk); service = 1; step();
    repeat (9) do_tick();
    chk("R5 no alarm after service", int'(alarm), 0);
    do_tick();
    chk("R5 alarm after full count", int'(alarm), 1);
    wr_ctl(0, 0, 1, 5'h02);

    // R10: service and tick together
    wr_ctl(0, 1, 1, 5'h02);
    wr_tmo(6);
    repeat (5) do_tick();
    @(negedge clk); service = 1; tick = 1; step();
    chk("R10 same-cycle service wins", int'(alarm), 0);
    repeat (5) do_tick();
    chk("R10 tick not counted", int'(alarm), 0);
    do_tick();
    chk("R10 trip after full count", int'(alarm), 1);
    wr_ctl(0, 0, 1, 5'h02);

    // R6: timeout write restarts
    wr_ctl(0, 1, 1, 5'h02);
    wr_tmo(20);
    repeat (10) do_tick();
    wr_tmo(4);
    repeat (3) do_tick();
    chk("R6 restart with new value", int'(alarm), 0);
    do_tick();
    chk("R6 trip at new value", int'(alarm), 1);
    wr_ctl(0, 0, 1, 5'h02);

    // R4: pause while disabled, resume without reload
    wr_tmo(8);
    wr_ctl(0, 1, 1, 5'h02);
    repeat (5) do_tick();
    wr_ctl(0, 0, 1, 5'h02);
    repeat (20) do_tick();
    chk("R4 no alarm while disabled", int'(alarm), 0);
    wr_ctl(0, 1, 1, 5'h02);
    do_tick(); do_tick();
    chk("R4 resumed count not reloaded", int'(alarm), 0);
    do_tick();
    chk("R4 trip after remaining ticks", int'(alarm), 1);
    wr_ctl(0, 0, 1, 5'h02);
    wr_tmo(1);
    repeat (6) do_tick();
    chk("R4 disabled short timeout stays quiet", int'(alarm), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule